// File: doc/BRIEF.md
# Packet Commit Buffer

This block holds the architectural side effects of one instruction packet until the packet ends. While the packet runs, the execution units send it general register writes, predicate writes, taken branches, and stores for two store slots. None of these become visible until a one-cycle commit pulse. On that edge the buffered register and predicate values are copied into the architectural copies, and the program counter takes either the recorded branch target or the sequential next address that comes with the commit. The uncancelled stores then leave on a byte-addressed memory write port, one per cycle.

Several parts of a packet can write the same predicate. These writes are combined by a bitwise AND. Only the first valid taken branch counts. Either store slot can be cancelled before commit. A load issued from slot 0 must see a store that slot 1 holds in the same packet, so that store is written to memory before the load is acknowledged. A store drained early in this way is not written again at commit.

A packet-start pulse clears all per-packet tracking. Inputs that arrive in the same cycle as a start or commit pulse are not captured.

Top module: `pkt_commit_buf`

## Requirements
- R1: After a synchronous active-low reset, every architectural register and predicate reads 0, `pc` equals `RESET_PC` (default 0), and `mem_we`, `br_fault` and `st_fault` are low.
- R2: A general register write is invisible on `rd_data` until the commit edge. After that edge the register shows the last value written to it in the packet, and registers not written keep their old value.
- R3: A predicate write keeps only bits 7:0 of `pw_data`. The first write to a predicate in a packet sets its buffered value, and each later write to it ANDs into that value. The result appears on `pq_data` only after commit.
- R4: Only the first valid branch in a packet is recorded, and later ones are ignored. On commit, `pc` becomes the recorded target. If no branch was recorded, `pc` becomes `pkt_next`. `pc` changes only on a commit edge.
- R5: A branch target whose low `ALIGN_BITS` (default 2) bits are not all zero is not recorded. It raises `br_fault` for the one cycle after the offending input, and it does not block a later aligned branch in the same packet.
- R6: A store is accepted only when `st_size`, a byte count, is 1, 2, 4 or 8. Any other size raises `st_fault` for one cycle and leaves the slot as it was.
- R7: At commit, the live stores are written one per cycle, slot 0 first. The first write is on the memory port in the cycle right after the commit edge, with `mem_addr`, `mem_size` and `mem_data` taken from the slot.
- R8: A slot cancelled through `st_cancel_en`/`st_cancel_slot` (0 = slot 0, 1 = slot 1) is not written to memory at commit.
- R9: A slot-0 load (`ld_slot`=0) requested while slot 1 holds an uncancelled, undrained store gets `ld_ack` low. In the next cycle that store is on the memory port and `ld_ack` is high. Any other load request is acknowledged in the same cycle.
- R10: A slot-1 store drained early for a slot-0 load is not written again at commit.
- R11: A packet-start pulse discards the buffered register writes, predicate writes, the recorded branch, the stores and the cancel mask of the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_start | input | 1 | Packet-start pulse, clears per-packet state |
| pkt_commit | input | 1 | Commit pulse, applies buffered effects |
| pkt_next | input | 32 | Sequential next address used when no branch was taken |
| rw_en | input | 1 | General register write strobe |
| rw_idx | input | log2(NREG) | General register index |
| rw_data | input | REG_W | General register write value |
| rd_idx | input | log2(NREG) | Architectural register read index |
| rd_data | output | REG_W | Architectural register read value |
| pw_en | input | 1 | Predicate write strobe |
| pw_idx | input | log2(NPRED) | Predicate index |
| pw_data | input | REG_W | Predicate write value, low 8 bits used |
| pq_idx | input | log2(NPRED) | Architectural predicate read index |
| pq_data | output | 8 | Architectural predicate read value |
| br_en | input | 1 | Taken branch strobe |
| br_target | input | 32 | Branch target address |
| pc | output | 32 | Architectural program counter |
| br_fault | output | 1 | Misaligned branch target pulse |
| st_en | input | 1 | Store capture strobe |
| st_slot | input | 1 | Store slot (0 or 1) |
| st_addr | input | 32 | Store byte address |
| st_size | input | 4 | Store size in bytes |
| st_data | input | 64 | Store data, right-aligned |
| st_fault | output | 1 | Illegal store size pulse |
| st_cancel_en | input | 1 | Slot cancel strobe |
| st_cancel_slot | input | 1 | Slot to cancel |
| ld_req | input | 1 | Load request |
| ld_slot | input | 1 | Slot issuing the load |
| ld_ack | output | 1 | Load may be performed this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_size | output | 4 | Memory write size in bytes |
| mem_data | output | 64 | Memory write data |

## Verification
The bench goes after the merge and ordering cases.

- Repeated predicate writes in one packet, with values whose upper bits would corrupt the result. A design that let a later write overwrite the value, or that kept bits above 7, would read back the wrong byte.
- Two taken branches in one packet, and a misaligned target followed by an aligned one. A design that kept the last branch, or that locked the packet on a faulty target, would land on the wrong PC.
- A slot-0 load against a pending slot-1 store. A design that acknowledged the load at once would let it read stale memory. A design that did not remember the early drain would write the same store twice at commit.
- Cancelled slots, and a packet start that must drop the previous packet's stores and cancel mask.

// File: rtl/pcb_pkg.sv
// Shared widths, the store record and the store size rule.
package pcb_pkg;
    localparam int ADDR_W = 32;
    localparam int ST_W   = 64;
    localparam int PRED_W = 8;
    localparam int SIZE_W = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [ST_W-1:0]   data;
    } st_rec_t;

    // A store size is a byte count of 1, 2, 4 or 8.
    function automatic logic size_ok(input logic [SIZE_W-1:0] s);
        return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
    endfunction
endpackage

// File: rtl/pcb_wlog.sv
// Write log for an indexed register file. Holds an architectural copy and
// a per-packet shadow copy with a written bit for each entry. AND_MERGE
// selects how repeated writes to one entry combine: 1 = AND into the
// buffered value, 0 = last write wins. Only the low W bits of the write
// data are kept. Assumes commit and clear are never captured together
// with a write (commit takes priority, then clear).
module pcb_wlog #(
    parameter int N         = 16,
    parameter int IN_W      = 32,
    parameter int W         = 32,
    parameter bit AND_MERGE = 1'b0,
    localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          commit,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [IN_W-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] arch_q   [N];
    logic [W-1:0] shadow_q [N];
    logic [N-1:0] dirty_q;
    logic [W-1:0] low_data;
    logic [W-1:0] merged;

    assign low_data = wr_data[W-1:0];

    generate
        if (IN_W > W) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^wr_data[IN_W-1:(IN_W > W ? W : 0)];
        end
        if (AND_MERGE) begin : g_and
            // Repeated writes AND into the buffered value.
            assign merged = dirty_q[wr_idx] ? (shadow_q[wr_idx] & low_data) : low_data;
        end else begin : g_last
            // The last write in the packet wins.
            assign merged = low_data;
        end
    endgenerate

    // Capture writes, apply them on commit, drop them on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                arch_q[i]   <= '0;
                shadow_q[i] <= '0;
            end
            dirty_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < N; i++) begin
                if (dirty_q[i]) arch_q[i] <= shadow_q[i];
            end
            dirty_q <= '0;
        end else if (clear) begin
            dirty_q <= '0;
        end else if (wr_en) begin
            shadow_q[wr_idx] <= merged;
            dirty_q[wr_idx]  <= 1'b1;
        end
    end

    assign rd_data = arch_q[rd_idx];
endmodule

// File: rtl/pcb_branch_log.sv
// Branch log and program counter. Keeps the first aligned taken branch of
// a packet and loads it, or the sequential address, into the PC on commit.
// A misaligned target is refused and reported one cycle later.
// Assumes ALIGN_BITS >= 1.
module pcb_branch_log #(
    parameter int          ALIGN_BITS = 2,
    parameter logic [31:0] RESET_PC   = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        commit,
    input  logic [31:0] seq_next,
    input  logic        br_en,
    input  logic [31:0] br_target,
    output logic [31:0] pc,
    output logic        fault
);
    logic        taken_q;
    logic [31:0] target_q;
    logic [31:0] pc_q;
    logic        fault_q;
    logic        misaligned;
    logic        capture;

    assign misaligned = |br_target[ALIGN_BITS-1:0];
    assign capture    = br_en && !taken_q && !commit && !clear;

    // Record the first aligned target, update the PC on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q  <= 1'b0;
            target_q <= '0;
            pc_q     <= RESET_PC;
            fault_q  <= 1'b0;
        end else begin
            fault_q <= capture && misaligned;
            if (commit) begin
                pc_q    <= taken_q ? target_q : seq_next;
                taken_q <= 1'b0;
            end else if (clear) begin
                taken_q <= 1'b0;
            end else if (capture && !misaligned) begin
                taken_q  <= 1'b1;
                target_q <= br_target;
            end
        end
    end

    assign pc    = pc_q;
    assign fault = fault_q;
endmodule

// File: rtl/pcb_store_log.sv
// Two-slot store log with cancel mask and memory write sequencer. On commit
// the live slots are written one per cycle, slot 0 first. A slot-0 load
// against a live slot-1 store is held off one cycle while that store is
// drained, and the drained store is not written again at commit.
// Assumes one load request at a time and a memory that takes one write per cycle.
module pcb_store_log
    import pcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              commit,
    input  logic              st_en,
    input  logic              st_slot,
    input  st_rec_t           st_in,
    input  logic              cancel_en,
    input  logic              cancel_slot,
    input  logic              ld_req,
    input  logic              ld_slot,
    output logic              ld_ack,
    output logic              st_fault,
    output logic              mem_we,
    output st_rec_t           mem_rec
);
    st_rec_t    rec_q [2];
    logic [1:0] valid_q;
    logic [1:0] cxl_q;
    logic       drained1_q;
    logic       tail_q;
    logic       mem_we_q;
    st_rec_t    mem_q;
    logic       fault_q;
    logic       live0;
    logic       live1;
    logic       hazard;
    logic       take;

    assign live0  = valid_q[0] && !cxl_q[0];
    assign live1  = valid_q[1] && !cxl_q[1] && !drained1_q;
    assign hazard = ld_req && !ld_slot && live1;
    assign ld_ack = ld_req && !hazard;
    assign take   = !commit && !clear;

    // Capture stores and cancels, and sequence the memory writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q[0]   <= '0;
            rec_q[1]   <= '0;
            valid_q    <= '0;
            cxl_q      <= '0;
            drained1_q <= 1'b0;
            tail_q     <= 1'b0;
            mem_we_q   <= 1'b0;
            mem_q      <= '0;
            fault_q    <= 1'b0;
        end else begin
            fault_q  <= st_en && !size_ok(st_in.size) && take;
            mem_we_q <= 1'b0;
            if (commit) begin
                valid_q    <= '0;
                cxl_q      <= '0;
                drained1_q <= 1'b0;
                if (live0) begin
                    mem_we_q <= 1'b1;
                    mem_q    <= rec_q[0];
                    tail_q   <= live1;
                end else if (live1) begin
                    mem_we_q <= 1'b1;
                    mem_q    <= rec_q[1];
                    tail_q   <= 1'b0;
                end
            end else begin
                if (tail_q) begin
                    mem_we_q <= 1'b1;
                    mem_q    <= rec_q[1];
                    tail_q   <= 1'b0;
                end else if (hazard) begin
                    mem_we_q   <= 1'b1;
                    mem_q      <= rec_q[1];
                    drained1_q <= 1'b1;
                end
                if (clear) begin
                    valid_q    <= '0;
                    cxl_q      <= '0;
                    drained1_q <= 1'b0;
                end else begin
                    if (st_en && size_ok(st_in.size)) begin
                        rec_q[st_slot]   <= st_in;
                        valid_q[st_slot] <= 1'b1;
                    end
                    if (cancel_en) cxl_q[cancel_slot] <= 1'b1;
                end
            end
        end
    end

    assign mem_we   = mem_we_q;
    assign mem_rec  = mem_q;
    assign st_fault = fault_q;
endmodule

// File: rtl/pkt_commit_buf.sv
// Packet commit buffer top. Joins the general register log, the predicate
// log (AND merge, 8-bit values), the branch log and the store log under
// one packet-start / commit control. Commit takes priority over start when
// both pulse in the same cycle.
module pkt_commit_buf #(
    parameter int          NREG       = 16,
    parameter int          NPRED      = 4,
    parameter int          REG_W      = 32,
    parameter int          ALIGN_BITS = 2,
    parameter logic [31:0] RESET_PC   = 32'h0,
    localparam int         RIDX_W     = $clog2(NREG),
    localparam int         PIDX_W     = $clog2(NPRED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_commit,
    input  logic [31:0]       pkt_next,
    input  logic              rw_en,
    input  logic [RIDX_W-1:0] rw_idx,
    input  logic [REG_W-1:0]  rw_data,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [REG_W-1:0]  rd_data,
    input  logic              pw_en,
    input  logic [PIDX_W-1:0] pw_idx,
    input  logic [REG_W-1:0]  pw_data,
    input  logic [PIDX_W-1:0] pq_idx,
    output logic [7:0]        pq_data,
    input  logic              br_en,
    input  logic [31:0]       br_target,
    output logic [31:0]       pc,
    output logic              br_fault,
    input  logic              st_en,
    input  logic              st_slot,
    input  logic [31:0]       st_addr,
    input  logic [3:0]        st_size,
    input  logic [63:0]       st_data,
    output logic              st_fault,
    input  logic              st_cancel_en,
    input  logic              st_cancel_slot,
    input  logic              ld_req,
    input  logic              ld_slot,
    output logic              ld_ack,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_size,
    output logic [63:0]       mem_data
);
    import pcb_pkg::*;

    st_rec_t st_in;
    st_rec_t mem_rec;

    assign st_in = '{addr: st_addr, size: st_size, data: st_data};

    pcb_wlog #(.N(NREG), .IN_W(REG_W), .W(REG_W), .AND_MERGE(1'b0)) u_gpr (
        .clk(clk), .rst_n(rst_n), .clear(pkt_start), .commit(pkt_commit),
        .wr_en(rw_en), .wr_idx(rw_idx), .wr_data(rw_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    pcb_wlog #(.N(NPRED), .IN_W(REG_W), .W(PRED_W), .AND_MERGE(1'b1)) u_pred (
        .clk(clk), .rst_n(rst_n), .clear(pkt_start), .commit(pkt_commit),
        .wr_en(pw_en), .wr_idx(pw_idx), .wr_data(pw_data),
        .rd_idx(pq_idx), .rd_data(pq_data)
    );

    pcb_branch_log #(.ALIGN_BITS(ALIGN_BITS), .RESET_PC(RESET_PC)) u_br (
        .clk(clk), .rst_n(rst_n), .clear(pkt_start), .commit(pkt_commit),
        .seq_next(pkt_next), .br_en(br_en), .br_target(br_target),
        .pc(pc), .fault(br_fault)
    );

    pcb_store_log u_st (
        .clk(clk), .rst_n(rst_n), .clear(pkt_start), .commit(pkt_commit),
        .st_en(st_en), .st_slot(st_slot), .st_in(st_in),
        .cancel_en(st_cancel_en), .cancel_slot(st_cancel_slot),
        .ld_req(ld_req), .ld_slot(ld_slot), .ld_ack(ld_ack),
        .st_fault(st_fault), .mem_we(mem_we), .mem_rec(mem_rec)
    );

    assign mem_addr = mem_rec.addr;
    assign mem_size = mem_rec.size;
    assign mem_data = mem_rec.data;
endmodule

// File: rtl/pcb_chk.sv
// Protocol checker for pkt_commit_buf, attached through bind.
module pcb_chk #(
    parameter int ALIGN_BITS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_commit,
    input logic        br_en,
    input logic [31:0] br_target,
    input logic        br_fault,
    input logic [31:0] pc,
    input logic        st_en,
    input logic [3:0]  st_size,
    input logic        st_fault,
    input logic        ld_req,
    input logic        ld_slot,
    input logic        ld_ack,
    input logic        mem_we,
    input logic [3:0]  mem_size
);
    AST_LD_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_slot && !ld_ack) |=> mem_we); // R9
    AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |-> ld_req); // R9
    AST_SLOT1_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_slot) |-> ld_ack); // R9
    AST_BR_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        br_fault |-> $past(br_en && (br_target[ALIGN_BITS-1:0] != '0))); // R5
    AST_ST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> $past(st_en && !pcb_pkg::size_ok(st_size))); // R6
    AST_MEM_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> pcb_pkg::size_ok(mem_size)); // R6
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_commit |=> $stable(pc)); // R4
endmodule

bind pkt_commit_buf pcb_chk #(.ALIGN_BITS(ALIGN_BITS)) u_pcb_chk (
    .clk(clk), .rst_n(rst_n), .pkt_commit(pkt_commit),
    .br_en(br_en), .br_target(br_target), .br_fault(br_fault), .pc(pc),
    .st_en(st_en), .st_size(st_size), .st_fault(st_fault),
    .ld_req(ld_req), .ld_slot(ld_slot), .ld_ack(ld_ack),
    .mem_we(mem_we), .mem_size(mem_size)
);

// File: tb/tb_pkt_commit_buf.sv
// Self-checking bench for pkt_commit_buf: predicate merge table, then
// directed tests for registers, branches, stores and load ordering.
module tb_pkt_commit_buf;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pkt_start, pkt_commit;
    logic [31:0] pkt_next;
    logic        rw_en;
    logic [3:0]  rw_idx, rd_idx;
    logic [31:0] rw_data, rd_data;
    logic        pw_en;
    logic [1:0]  pw_idx, pq_idx;
    logic [31:0] pw_data;
    logic [7:0]  pq_data;
    logic        br_en;
    logic [31:0] br_target, pc;
    logic        br_fault;
    logic        st_en, st_slot;
    logic [31:0] st_addr;
    logic [3:0]  st_size;
    logic [63:0] st_data;
    logic        st_fault;
    logic        st_cancel_en, st_cancel_slot;
    logic        ld_req, ld_slot, ld_ack;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_size;
    logic [63:0] mem_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] pexp [4];

    // Fields: predicate index, three write values, expected committed byte.
    localparam logic [111:0] PVEC [5] = '{
        {8'd0, 32'h0000_12F3, 32'hFFFF_FF3C, 32'hFFFF_FFFF, 8'h30},
        {8'd1, 32'hABCD_EF5A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h5A},
        {8'd2, 32'h0000_00FF, 32'h0000_000F, 32'h0000_00F0, 8'h00},
        {8'd3, 32'h0000_0180, 32'h0000_00C0, 32'hFFFF_FF81, 8'h80},
        {8'd0, 32'h0000_0077, 32'h0000_007F, 32'h1234_56F7, 8'h77}
    };

    always #10 clk = ~clk;

    pkt_commit_buf dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_commit(pkt_commit),
        .pkt_next(pkt_next), .rw_en(rw_en), .rw_idx(rw_idx), .rw_data(rw_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .pw_en(pw_en), .pw_idx(pw_idx),
        .pw_data(pw_data), .pq_idx(pq_idx), .pq_data(pq_data), .br_en(br_en),
        .br_target(br_target), .pc(pc), .br_fault(br_fault), .st_en(st_en),
        .st_slot(st_slot), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .st_fault(st_fault), .st_cancel_en(st_cancel_en), .st_cancel_slot(st_cancel_slot),
        .ld_req(ld_req), .ld_slot(ld_slot), .ld_ack(ld_ack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic t_start();
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
    endtask
    task automatic t_commit(input logic [31:0] nxt);
        pkt_commit = 1'b1; pkt_next = nxt; @(negedge clk); pkt_commit = 1'b0;
    endtask
    task automatic t_rw(input logic [3:0] i, input logic [31:0] d);
        rw_en = 1'b1; rw_idx = i; rw_data = d; @(negedge clk); rw_en = 1'b0;
    endtask
    task automatic t_pw(input logic [1:0] i, input logic [31:0] d);
        pw_en = 1'b1; pw_idx = i; pw_data = d; @(negedge clk); pw_en = 1'b0;
    endtask
    task automatic t_br(input logic [31:0] t);
        br_en = 1'b1; br_target = t; @(negedge clk); br_en = 1'b0;
    endtask
    task automatic t_st(input logic s, input logic [31:0] a, input logic [3:0] z, input logic [63:0] d);
        st_en = 1'b1; st_slot = s; st_addr = a; st_size = z; st_data = d;
        @(negedge clk); st_en = 1'b0;
    endtask
    task automatic t_cancel(input logic s);
        st_cancel_en = 1'b1; st_cancel_slot = s; @(negedge clk); st_cancel_en = 1'b0;
    endtask

    initial begin
        #(20ns * 50000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; pkt_start = 0; pkt_commit = 0; pkt_next = 0;
        rw_en = 0; rw_idx = 0; rw_data = 0; rd_idx = 0;
        pw_en = 0; pw_idx = 0; pw_data = 0; pq_idx = 0;
        br_en = 0; br_target = 0; st_en = 0; st_slot = 0; st_addr = 0;
        st_size = 0; st_data = 0; st_cancel_en = 0; st_cancel_slot = 0;
        ld_req = 0; ld_slot = 0;
        for (int i = 0; i < 4; i++) pexp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_idx = 4'd3; pq_idx = 2'd2; #1;
        chk("R1 reg", rd_data, 0);
        chk("R1 pred", pq_data, 0);
        chk("R1 pc", pc, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 faults", {br_fault, st_fault}, 0);

        // R3: predicate merge table
        for (int v = 0; v < 5; v++) begin
            logic [1:0] pi;
            pi = PVEC[v][105:104];
            t_start();
            t_pw(pi, PVEC[v][103:72]);
            t_pw(pi, PVEC[v][71:40]);
            t_pw(pi, PVEC[v][39:8]);
            pq_idx = pi; #1;
            chk("R3 hidden before commit", pq_data, pexp[pi]);
            t_commit(32'h10);
            pexp[pi] = PVEC[v][7:0];
            chk("R3 merged value", pq_data, pexp[pi]);
        end

        // R2: register writes, last wins, visible only after commit
        t_start();
        t_rw(4'd5, 32'hAAAA_0001);
        t_rw(4'd5, 32'hBBBB_0002);
        t_rw(4'd6, 32'h0000_1234);
        rd_idx = 4'd5; #1;
        chk("R2 hidden before commit", rd_data, 0);
        t_commit(32'h20);
        chk("R2 last write", rd_data, 32'hBBBB_0002);
        rd_idx = 4'd6; #1; chk("R2 second reg", rd_data, 32'h1234);
        rd_idx = 4'd7; #1; chk("R2 unwritten reg", rd_data, 0);

        // R4: first branch wins; sequential address otherwise
        t_start();
        t_br(32'h100);
        t_br(32'h200);
        chk("R4 pc before commit", pc, 32'h20);
        t_commit(32'h40);
        chk("R4 first branch", pc, 32'h100);
        t_start();
        t_commit(32'h44);
        chk("R4 fall through", pc, 32'h44);

        // R5: misaligned target refused, later aligned kept
        t_start();
        t_br(32'h103);
        chk("R5 fault pulse", br_fault, 1);
        t_br(32'h300);
        chk("R5 fault clears", br_fault, 0);
        t_commit(32'h48);
        chk("R5 aligned after fault", pc, 32'h300);

        // R6: illegal size refused, slot keeps its earlier store
        t_start();
        t_st(1'b0, 32'h2000, 4'd2, 64'hBEEF);
        chk("R6 legal no fault", st_fault, 0);
        t_st(1'b0, 32'h3000, 4'd5, 64'h1111);
        chk("R6 illegal fault", st_fault, 1);
        t_commit(32'h50);
        chk("R6 slot kept addr", mem_addr, 32'h2000);
        chk("R6 slot kept size", mem_size, 2);

        // R7: slot 0 then slot 1 on consecutive cycles
        @(negedge clk);
        t_start();
        t_st(1'b1, 32'h500, 4'd8, 64'h0102_0304_0506_0708);
        t_st(1'b0, 32'h400, 4'd1, 64'h00AB);
        t_commit(32'h54);
        chk("R7 first we", mem_we, 1);
        chk("R7 first addr", mem_addr, 32'h400);
        chk("R7 first data", mem_data, 64'h00AB);
        @(negedge clk);
        chk("R7 second we", mem_we, 1);
        chk("R7 second addr", mem_addr, 32'h500);
        chk("R7 second size", mem_size, 8);
        chk("R7 second data", mem_data, 64'h0102_0304_0506_0708);
        @(negedge clk);
        chk("R7 done", mem_we, 0);

        // R8: cancelled slots are not written
        t_start();
        t_st(1'b0, 32'h600, 4'd4, 64'h6);
        t_st(1'b1, 32'h700, 4'd2, 64'h7);
        t_cancel(1'b0);
        t_commit(32'h58);
        chk("R8 only slot1 we", mem_we, 1);
        chk("R8 only slot1 addr", mem_addr, 32'h700);
        @(negedge clk);
        chk("R8 slot0 dropped", mem_we, 0);
        t_start();
        t_st(1'b0, 32'h610, 4'd4, 64'h6);
        t_st(1'b1, 32'h710, 4'd2, 64'h7);
        t_cancel(1'b1);
        t_commit(32'h5C);
        chk("R8 slot0 addr", mem_addr, 32'h610);
        @(negedge clk);
        chk("R8 slot1 dropped", mem_we, 0);

        // R9 / R10: slot-0 load drains slot-1 store first
        t_start();
        t_st(1'b1, 32'h800, 4'd4, 64'hCAFE_F00D);
        ld_req = 1'b1; ld_slot = 1'b0; #1;
        chk("R9 load held", ld_ack, 0);
        chk("R9 no write yet", mem_we, 0);
        @(negedge clk);
        chk("R9 drain we", mem_we, 1);
        chk("R9 drain addr", mem_addr, 32'h800);
        chk("R9 drain data", mem_data, 64'hCAFE_F00D);
        chk("R9 load released", ld_ack, 1);
        ld_req = 1'b0;
        @(negedge clk);
        chk("R9 single drain", mem_we, 0);
        t_commit(32'h60);
        chk("R10 no rewrite", mem_we, 0);
        @(negedge clk);
        chk("R10 no rewrite later", mem_we, 0);

        // R9: loads with no hazard acknowledged at once
        t_start();
        t_st(1'b1, 32'h900, 4'd1, 64'h9);
        ld_req = 1'b1; ld_slot = 1'b1; #1;
        chk("R9 slot1 load free", ld_ack, 1);
        ld_req = 1'b0;
        t_cancel(1'b1);
        ld_req = 1'b1; ld_slot = 1'b0; #1;
        chk("R9 cancelled store no hold", ld_ack, 1);
        ld_req = 1'b0;
        t_commit(32'h64);
        chk("R9 cancelled not written", mem_we, 0);

        // R11: packet start discards the packet in progress
        t_start();
        t_rw(4'd2, 32'h55);
        t_pw(2'd1, 32'h0F);
        t_br(32'hA00);
        t_st(1'b0, 32'hB00, 4'd4, 64'h1);
        t_start();
        t_commit(32'h68);
        rd_idx = 4'd2; pq_idx = 2'd1; #1;
        chk("R11 reg discarded", rd_data, 0);
        chk("R11 pred discarded", pq_data, pexp[1]);
        chk("R11 branch discarded", pc, 32'h68);
        chk("R11 store discarded", mem_we, 0);
        t_start();
        t_cancel(1'b0);
        t_start();
        t_st(1'b0, 32'hC00, 4'd1, 64'h2);
        t_commit(32'h6C);
        chk("R11 cancel mask cleared", mem_we, 1);
        chk("R11 cancel mask addr", mem_addr, 32'hC00);

        @(negedge clk);
        summary();
    end
endmodule